// File: doc/BRIEF.md
# SDRAM Bank Timing Tracker

This block sits beside an SDRAM command scheduler and follows the commands the scheduler issues. From that stream it models the internal state of every bank, and it tells the scheduler when each bank can take a new ACTIVE. It also times the read data window and reports which write beats really landed in a bank.

The hard case is a write burst with auto precharge that is cut short. A READ or WRITE to another bank ends the write at once. The beat on the interrupting cycle belongs to the new burst, so the interrupted burst keeps only the beats up to the cycle before. Write recovery for the interrupted bank starts on the interrupting cycle. When recovery is done the bank precharges for the row-precharge time and then returns to idle. A burst that runs to the end with auto precharge starts write recovery on its final beat.

Timing values are parameters given in clock cycles: write recovery, row precharge, CAS latency and burst length. The bank count is also a parameter.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset, every bank is idle. `bankReady` is all ones, and `actError`, `rdDataValid` and `wrEndValid` are low.
- R2: Command codes on `cmdOp` are 0 NOP, 1 ACTIVE, 2 READ and 3 WRITE, and a command is taken only when `cmdValid` is high. An ACTIVE to an idle bank moves that bank to ACTIVE at the clock edge that registers the command.
- R3: An ACTIVE to a bank that is not idle raises `actError` for the one cycle after the edge that registers it, and leaves that bank's state unchanged.
- R4: A WRITE with auto precharge that is not interrupted takes BURST_LEN beats, the first on the command edge. On the edge of the final beat the bank enters write recovery for T_WR cycles, then precharges for T_RP cycles, then becomes idle. On that same edge a `wrEndValid` pulse reports beat index BURST_LEN-1.
- R5: A WRITE without auto precharge returns its bank to ACTIVE on the final-beat edge and reports beat index BURST_LEN-1.
- R6: A READ to another bank, registered while bank n is in a write burst, ends that burst. `wrEndBank` is n, and `wrEndBeat` is the index of the beat registered one edge before the READ. With auto precharge, write recovery for bank n starts at the READ edge.
- R7: A WRITE to another bank ends a write burst in the same way as R6. The new write, if it has auto precharge, starts its own recovery after its own final beat.
- R8: `rdDataValid` is high in the cycles that end CAS_LAT edges after each read beat slot. A read burst has BURST_LEN slots, the first on the READ edge.
- R9: A READ with auto precharge moves its bank to precharging for T_RP cycles on the edge of its last slot, and the bank then becomes idle.
- R10: Each bank's state on `bankState[3*b+2:3*b]` is coded 0 IDLE, 1 ACTIVE, 2 WRITE_BURST, 3 READ_BURST, 4 WRITE_RECOVERY and 5 PRECHARGING. `bankReady[b]` is high only when that code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is issued this cycle |
| cmdOp | input | 2 | Command code (0 NOP, 1 ACTIVE, 2 READ, 3 WRITE) |
| cmdBank | input | $clog2(NUM_BANKS) | Target bank |
| cmdAutoPre | input | 1 | Auto precharge requested with a READ or WRITE |
| bankState | output | 3*NUM_BANKS | Per-bank state codes |
| bankReady | output | NUM_BANKS | Bank can take an ACTIVE |
| actError | output | 1 | ACTIVE was issued to a bank that was not idle |
| rdDataValid | output | 1 | Read data is on the bus this cycle |
| wrEndValid | output | 1 | A write burst ended at the last edge |
| wrEndBank | output | $clog2(NUM_BANKS) | Bank whose write burst ended |
| wrEndBeat | output | $clog2(BURST_LEN) | Index of the last beat kept by that burst |

## Verification
On every cycle, the assertions check several properties. Write recovery only stays put or moves to precharge, and precharge only stays put or moves to idle. At most one bank is in a write burst, a recovery counter never counts down from zero, and an ACTIVE to a busy bank is always followed by the error flag. The exact cycle counts can be shown only by the bench's scenarios: the recovery and precharge lengths, the index of the last beat kept by an interrupted burst, and where the read data window falls after CAS latency.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACTIVE  = 3'd1,
    ST_WRBURST = 3'd2,
    ST_RDBURST = 3'd3,
    ST_WRREC   = 3'd4,
    ST_PRECH   = 3'd5
  } bankStateT;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } cmdOpT;

  // strobes from the bank control to the bank datapath
  typedef struct packed {
    logic beatClr;
    logic beatInc;
    logic loadWr;
    logic loadRp;
    logic cntDec;
    logic wrEnd;
  } bankStrobeT;

endpackage

// File: rtl/trk_ctrl.sv
module trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              cmdAutoPre,
  input  logic              beatNearEnd [NUM_BANKS],
  input  logic              cntOne [NUM_BANKS],
  output bankStateT         stateQ [NUM_BANKS],
  output bankStrobeT        strobe [NUM_BANKS],
  output logic              readSlot,
  output logic              actError
);

  bankStateT stateD [NUM_BANKS];
  logic [NUM_BANKS-1:0] apQ, apD;
  logic [NUM_BANKS-1:0] hitV, otherV, wrBurstV;
  logic isRw, isAct, errD;

  always_comb begin
    isRw     = cmdValid && (cmdOp == OP_RD || cmdOp == OP_WR);
    isAct    = cmdValid && (cmdOp == OP_ACT);
    readSlot = 1'b0;
    errD     = 1'b0;
    apD      = apQ;
    for (int b = 0; b < NUM_BANKS; b++) begin
      hitV[b]     = cmdValid && (cmdBank == BANK_W'(b));
      otherV[b]   = isRw && !hitV[b];
      wrBurstV[b] = (stateQ[b] == ST_WRBURST);
      stateD[b]   = stateQ[b];
      strobe[b]   = '0;
      if (isAct && hitV[b] && stateQ[b] != ST_IDLE) errD = 1'b1;
      case (stateQ[b])
        ST_IDLE: begin
          if (isAct && hitV[b]) stateD[b] = ST_ACTIVE;
        end
        ST_ACTIVE, ST_WRBURST, ST_RDBURST: begin
          if (isRw && hitV[b]) begin
            stateD[b]         = (cmdOp == OP_RD) ? ST_RDBURST : ST_WRBURST;
            apD[b]            = cmdAutoPre;
            strobe[b].beatClr = 1'b1;
            if (cmdOp == OP_RD) readSlot = 1'b1;
          end else if (stateQ[b] == ST_WRBURST) begin
            strobe[b].beatInc = !otherV[b];
            if (otherV[b] || beatNearEnd[b]) begin
              strobe[b].wrEnd  = 1'b1;
              strobe[b].loadWr = apQ[b];
              stateD[b]        = apQ[b] ? ST_WRREC : ST_ACTIVE;
            end
          end else if (stateQ[b] == ST_RDBURST) begin
            strobe[b].beatInc = !otherV[b];
            if (!isRw) readSlot = 1'b1;
            if (otherV[b] || beatNearEnd[b]) begin
              strobe[b].loadRp = apQ[b];
              stateD[b]        = apQ[b] ? ST_PRECH : ST_ACTIVE;
            end
          end
        end
        ST_WRREC: begin
          if (cntOne[b]) begin
            stateD[b]        = ST_PRECH;
            strobe[b].loadRp = 1'b1;
          end else begin
            strobe[b].cntDec = 1'b1;
          end
        end
        ST_PRECH: begin
          if (cntOne[b]) stateD[b] = ST_IDLE;
          else strobe[b].cntDec = 1'b1;
        end
        default: stateD[b] = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) stateQ[b] <= ST_IDLE;
      apQ      <= '0;
      actError <= 1'b0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) stateQ[b] <= stateD[b];
      apQ      <= apD;
      actError <= errD;
    end
  end

  AST_SINGLE_WRITE_BURST: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrBurstV)); // R6

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gChk
    AST_WREC_EXIT: assert property (@(posedge clk) disable iff (!rstN)
      (stateQ[g] == ST_WRREC) |=> (stateQ[g] == ST_WRREC || stateQ[g] == ST_PRECH)); // R4
    AST_PRECH_EXIT: assert property (@(posedge clk) disable iff (!rstN)
      (stateQ[g] == ST_PRECH) |=> (stateQ[g] == ST_PRECH || stateQ[g] == ST_IDLE)); // R9
  end

endmodule

// File: rtl/trk_dp.sv
module trk_dp
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  parameter int CAS_LAT   = 3,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int BEAT_W = $clog2(BURST_LEN),
  localparam int T_MAX  = (T_WR > T_RP) ? T_WR : T_RP,
  localparam int CNT_W  = $clog2(T_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobeT        strobe [NUM_BANKS],
  input  logic              readSlot,
  output logic              beatNearEnd [NUM_BANKS],
  output logic              cntOne [NUM_BANKS],
  output logic              rdDataValid,
  output logic              wrEndValid,
  output logic [BANK_W-1:0] wrEndBank,
  output logic [BEAT_W-1:0] wrEndBeat
);

  logic [BEAT_W-1:0] beatCnt [NUM_BANKS];
  logic [CNT_W-1:0]  cnt [NUM_BANKS];
  logic [CAS_LAT-1:0] rdPipe;
  logic              endValidD;
  logic [BANK_W-1:0] endBankD;
  logic [BEAT_W-1:0] endBeatD;

  always_comb begin
    endValidD = 1'b0;
    endBankD  = '0;
    endBeatD  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      beatNearEnd[b] = (beatCnt[b] == BEAT_W'(BURST_LEN - 2));
      cntOne[b]      = (cnt[b] == CNT_W'(1));
      if (strobe[b].wrEnd) begin
        endValidD = 1'b1;
        endBankD  = BANK_W'(b);
        endBeatD  = strobe[b].beatInc ? beatCnt[b] + 1'b1 : beatCnt[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        beatCnt[b] <= '0;
        cnt[b]     <= '0;
      end
      rdPipe     <= '0;
      wrEndValid <= 1'b0;
      wrEndBank  <= '0;
      wrEndBeat  <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (strobe[b].beatClr)      beatCnt[b] <= '0;
        else if (strobe[b].beatInc) beatCnt[b] <= beatCnt[b] + 1'b1;
        if (strobe[b].loadWr)       cnt[b] <= CNT_W'(T_WR);
        else if (strobe[b].loadRp)  cnt[b] <= CNT_W'(T_RP);
        else if (strobe[b].cntDec)  cnt[b] <= cnt[b] - 1'b1;
      end
      rdPipe[0] <= readSlot;
      for (int i = 1; i < CAS_LAT; i++) rdPipe[i] <= rdPipe[i-1];
      wrEndValid <= endValidD;
      wrEndBank  <= endBankD;
      wrEndBeat  <= endBeatD;
    end
  end

  assign rdDataValid = rdPipe[CAS_LAT-1];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gChk
    AST_NO_COUNT_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      strobe[g].cntDec |-> (cnt[g] != '0)); // R4
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  parameter int CAS_LAT   = 3,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int BEAT_W = $clog2(BURST_LEN)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic [1:0]             cmdOp,
  input  logic [BANK_W-1:0]      cmdBank,
  input  logic                   cmdAutoPre,
  output logic [3*NUM_BANKS-1:0] bankState,
  output logic [NUM_BANKS-1:0]   bankReady,
  output logic                   actError,
  output logic                   rdDataValid,
  output logic                   wrEndValid,
  output logic [BANK_W-1:0]      wrEndBank,
  output logic [BEAT_W-1:0]      wrEndBeat
);

  bankStateT  stateQ [NUM_BANKS];
  bankStrobeT strobe [NUM_BANKS];
  logic       beatNearEnd [NUM_BANKS];
  logic       cntOne [NUM_BANKS];
  logic       readSlot;

  trk_ctrl #(.NUM_BANKS(NUM_BANKS)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBank(cmdBank), .cmdAutoPre(cmdAutoPre), .beatNearEnd(beatNearEnd),
    .cntOne(cntOne), .stateQ(stateQ), .strobe(strobe), .readSlot(readSlot),
    .actError(actError)
  );

  trk_dp #(
    .NUM_BANKS(NUM_BANKS), .BURST_LEN(BURST_LEN), .T_WR(T_WR),
    .T_RP(T_RP), .CAS_LAT(CAS_LAT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readSlot(readSlot),
    .beatNearEnd(beatNearEnd), .cntOne(cntOne), .rdDataValid(rdDataValid),
    .wrEndValid(wrEndValid), .wrEndBank(wrEndBank), .wrEndBeat(wrEndBeat)
  );

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      bankState[3*b +: 3] = stateQ[b];
      bankReady[b]        = (stateQ[b] == ST_IDLE);
    end
  end

  AST_BAD_ACT_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd1 && !bankReady[cmdBank]) |=> actError); // R3

endmodule

// File: tb/tb_sdram_bank_tracker.sv
module tb_sdram_bank_tracker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [1:0] cmdBank = 2'd0;
  logic cmdAutoPre = 1'b0;
  logic [11:0] bankState;
  logic [3:0] bankReady;
  logic actError, rdDataValid, wrEndValid;
  logic [1:0] wrEndBank, wrEndBeat;

  int total = 0;
  int bad = 0;
  bit done = 0;

  sdram_bank_tracker dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBank(cmdBank), .cmdAutoPre(cmdAutoPre), .bankState(bankState),
    .bankReady(bankReady), .actError(actError), .rdDataValid(rdDataValid),
    .wrEndValid(wrEndValid), .wrEndBank(wrEndBank), .wrEndBeat(wrEndBeat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int st(int b);
    return int'(bankState[3*b +: 3]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one command for one edge, return at the following falling edge
  task automatic cyc(int op, int bank, bit ap);
    cmdValid   = (op != 0);
    cmdOp      = 2'(op);
    cmdBank    = 2'(bank);
    cmdAutoPre = ap;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd0; cmdAutoPre = 1'b0;
  endtask

  task automatic t_reset();
    for (int b = 0; b < 4; b++) chk("R1", "state", st(b), 0);
    chk("R10", "ready", int'(bankReady), 15);
    chk("R1", "actError", int'(actError), 0);
    chk("R1", "rdDataValid", int'(rdDataValid), 0);
    chk("R1", "wrEndValid", int'(wrEndValid), 0);
  endtask

  task automatic t_activate();
    cyc(1, 0, 0);
    chk("R2", "bank0 state", st(0), 1);
    chk("R10", "bank0 ready", int'(bankReady[0]), 0);
    chk("R2", "bank1 state", st(1), 0);
    cyc(1, 0, 0);
    chk("R3", "actError", int'(actError), 1);
    chk("R3", "bank0 state kept", st(0), 1);
    cyc(0, 0, 0);
    chk("R3", "actError clears", int'(actError), 0);
  endtask

  task automatic t_write_ap_full();
    cyc(3, 0, 1);                       // E0
    chk("R4", "burst state", st(0), 2);
    cyc(0, 0, 0); cyc(0, 0, 0);         // E1 E2
    chk("R4", "still burst", st(0), 2);
    chk("R4", "no early end", int'(wrEndValid), 0);
    cyc(0, 0, 0);                       // E3
    chk("R4", "wrEndValid", int'(wrEndValid), 1);
    chk("R4", "wrEndBeat", int'(wrEndBeat), 3);
    chk("R4", "wrEndBank", int'(wrEndBank), 0);
    chk("R4", "recovery", st(0), 4);
    cyc(0, 0, 0);                       // E4
    chk("R4", "recovery 2", st(0), 4);
    cyc(0, 0, 0);                       // E5
    chk("R4", "precharge", st(0), 5);
    cyc(0, 0, 0); cyc(0, 0, 0);         // E6 E7
    chk("R4", "precharge end", st(0), 5);
    cyc(0, 0, 0);                       // E8
    chk("R4", "idle", st(0), 0);
    chk("R10", "ready", int'(bankReady[0]), 1);
  endtask

  task automatic t_write_noap();
    cyc(1, 2, 0);
    cyc(3, 2, 0);
    cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
    chk("R5", "back to active", st(2), 1);
    chk("R5", "wrEndBeat", int'(wrEndBeat), 3);
    chk("R5", "wrEndBank", int'(wrEndBank), 2);
  endtask

  task automatic t_int_read();
    cyc(1, 0, 0); cyc(1, 1, 0);
    cyc(3, 0, 1);                       // E0
    cyc(0, 0, 0);                       // E1
    cyc(2, 1, 0);                       // E2 interrupting read
    chk("R6", "wrEndValid", int'(wrEndValid), 1);
    chk("R6", "wrEndBank", int'(wrEndBank), 0);
    chk("R6", "wrEndBeat", int'(wrEndBeat), 1);
    chk("R6", "bank0 recovery", st(0), 4);
    chk("R6", "bank1 read", st(1), 3);
    chk("R8", "no data yet", int'(rdDataValid), 0);
    cyc(0, 0, 0);                       // E3
    chk("R8", "no data E3", int'(rdDataValid), 0);
    cyc(0, 0, 0);                       // E4
    chk("R8", "data first", int'(rdDataValid), 1);
    chk("R6", "bank0 precharge", st(0), 5);
    cyc(0, 0, 0);                       // E5
    chk("R8", "bank1 active", st(1), 1);
    cyc(0, 0, 0);                       // E6
    chk("R6", "bank0 still precharge", st(0), 5);
    cyc(0, 0, 0);                       // E7
    chk("R6", "bank0 idle", st(0), 0);
    chk("R8", "data last", int'(rdDataValid), 1);
    cyc(0, 0, 0);                       // E8
    chk("R8", "data over", int'(rdDataValid), 0);
  endtask

  task automatic t_int_write();
    cyc(1, 0, 0);
    cyc(3, 0, 1);                       // E0
    cyc(0, 0, 0); cyc(0, 0, 0);         // E1 E2
    cyc(3, 1, 1);                       // E3 interrupting write
    chk("R7", "wrEndBank", int'(wrEndBank), 0);
    chk("R7", "wrEndBeat", int'(wrEndBeat), 2);
    chk("R7", "bank0 recovery", st(0), 4);
    chk("R7", "bank1 burst", st(1), 2);
    cyc(0, 0, 0); cyc(0, 0, 0);         // E4 E5
    chk("R7", "bank1 burst on", st(1), 2);
    cyc(0, 0, 0);                       // E6
    chk("R7", "bank1 wrEndBank", int'(wrEndBank), 1);
    chk("R7", "bank1 wrEndBeat", int'(wrEndBeat), 3);
    chk("R7", "bank1 recovery", st(1), 4);
    cyc(0, 0, 0); cyc(0, 0, 0);         // E7 E8
    chk("R7", "bank0 idle", st(0), 0);
    chk("R7", "bank1 precharge", st(1), 5);
    cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0); // E9..E11
    chk("R7", "bank1 idle", st(1), 0);
  endtask

  task automatic t_read_ap();
    cyc(1, 3, 0);
    cyc(2, 3, 1);                       // E0
    chk("R9", "read burst", st(3), 3);
    cyc(0, 0, 0);                       // E1
    cyc(0, 0, 0);                       // E2
    chk("R8", "data first", int'(rdDataValid), 1);
    cyc(0, 0, 0);                       // E3
    chk("R9", "precharge", st(3), 5);
    cyc(0, 0, 0);                       // E4
    cyc(1, 3, 0);                       // E5 ACTIVE while precharging
    chk("R3", "actError", int'(actError), 1);
    chk("R9", "still precharge", st(3), 5);
    chk("R8", "data last", int'(rdDataValid), 1);
    cyc(0, 0, 0);                       // E6
    chk("R9", "idle", st(3), 0);
    chk("R8", "data over", int'(rdDataValid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_activate();
    t_write_ap_full();
    t_write_noap();
    t_int_read();
    t_int_write();
    t_read_ap();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule